// File: doc/BRIEF.md
# Signal Quality Index Quantizer

This block reduces a receiver's 16-bit mean-square-error reading to a 3-bit quality grade from 0 (worst) to 7 (best). A larger error means a poorer channel, so the grade is found by walking a list of falling thresholds and stopping at the first one the reading reaches. The eight bins are one decibel wide, taken from SNR(dB) = -10*log10(MSE/2^17) - 1.76. Grade 0 covers signal-to-noise below 18 dB and grade 7 covers 24 dB and above.

A reading is handed in with a one-cycle strobe, together with the current link state. With the link up, a small controller steps an index through the threshold list, one entry per clock. A datapath compares the held reading against the selected entry and registers the grade together with a one-cycle valid pulse. With the link down, no comparison is made and grade 0 is reported at once. A constant output gives the highest grade the block can report. The thresholds are parameters.

Top module: `sqi_quantizer`

## Requirements
- R1: With the link up, the reported grade is the lowest index k whose threshold is less than or equal to the held reading. The default thresholds for k = 0..7 are 0x0569, 0x044C, 0x0369, 0x02B6, 0x0227, 0x01B6, 0x015B and 0x0000.
- R2: Any reading at or above 0x0569, including 0xFFFF, gives grade 0 when the link is up.
- R3: Any reading below 0x015B, including 0x0000, gives grade 7. The last threshold is zero, so every reading resolves to a grade.
- R4: With the link up, a reading that resolves to grade k raises `qualityValid` after exactly k+2 rising edges, counting the edge that samples the strobe. No scan takes more than 9 edges.
- R5: If `linkUp` is low on the edge that samples the strobe, the block reports grade 0 with `qualityValid` high after that single edge, whatever the reading.
- R6: `qualityValid` is high for exactly one cycle per accepted strobe.
- R7: A strobe that arrives while a scan is running, or in the cycle in which `qualityValid` is high, is ignored. It changes neither the grade being produced nor the number of results.
- R8: `qualityMax` always reads 7.
- R9: During and right after reset, `qualityValid` is 0 and `qualityIdx` is 0.
- R10: A reading exactly equal to threshold k gives grade k. A reading one below threshold k (k < 7) gives grade k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a new error reading |
| mseValue | input | 16 | Mean-square-error reading, unsigned |
| linkUp | input | 1 | Link state, sampled together with the strobe |
| qualityIdx | output | 3 | Registered quality grade, 0 worst, 7 best |
| qualityValid | output | 1 | One-cycle pulse when `qualityIdx` holds a new grade |
| qualityMax | output | 3 | Constant highest grade (7) |

## Verification
A controller index that skipped or repeated a step would show up at the ports on the first reading whose bin lies beyond the fault. The grade would be off by one or more, or the valid pulse would arrive earlier or later than k+2 edges, so the bench measures both for every bin edge. A controller that left its busy state early, or never left it, would show as a second valid pulse, a missing one, or a grade taken from a late strobe. This appears within nine edges of the strobe. A comparison wrong at equality would give the wrong grade on the exact-threshold readings.

// File: rtl/sqi_pkg.sv
package sqi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_REPORT = 2'd2
  } sqiState_t;

  // Strobes sent by the controller to the datapath.
  typedef struct packed {
    logic load;    // capture a new reading
    logic finish;  // scan ended: register the current index as the grade
    logic zero;    // link down: register grade 0
  } sqiCmd_t;

endpackage

// File: rtl/sqi_ctrl.sv
module sqi_ctrl
  import sqi_pkg::*;
#(
  parameter int NUM_BINS = 8,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             linkUp,
  input  logic             hit,
  output sqiCmd_t          cmd,
  output logic [IDX_W-1:0] scanIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  sqiState_t state;
  logic      atLast;

  assign atLast = (scanIdx == LAST_IDX);

  always_comb begin
    cmd.load   = (state == ST_IDLE) && sampleValid;
    cmd.zero   = (state == ST_IDLE) && sampleValid && !linkUp;
    cmd.finish = (state == ST_SCAN) && (hit || atLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          scanIdx <= '0;
          if (sampleValid) state <= linkUp ? ST_SCAN : ST_REPORT;
        end
        ST_SCAN: begin
          if (hit || atLast) state <= ST_REPORT;
          else scanIdx <= scanIdx + 1'b1;
        end
        ST_REPORT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R4: a scan never runs past the last table entry
  p_scan_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && atLast) |=> (state == ST_REPORT))
    else $error("scan ran past last entry");

  // R7: a running scan is never cut short back to idle
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |=> (state != ST_IDLE))
    else $error("scan aborted");

  // R6: report lasts a single cycle
  p_report_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPORT) |=> (state == ST_IDLE))
    else $error("report state held");

endmodule

// File: rtl/sqi_datapath.sv
module sqi_datapath
  import sqi_pkg::*;
#(
  parameter int MSE_W    = 16,
  parameter int NUM_BINS = 8,
  parameter logic [NUM_BINS*MSE_W-1:0] THRESHOLDS = '0,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sqiCmd_t          cmd,
  input  logic [IDX_W-1:0] scanIdx,
  input  logic [MSE_W-1:0] mseIn,
  output logic             hit,
  output logic [IDX_W-1:0] qualityIdx,
  output logic             qualityValid
);

  logic [MSE_W-1:0] thrTable [NUM_BINS];
  logic [MSE_W-1:0] mseHeld;

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_thr
    assign thrTable[g] = THRESHOLDS[g*MSE_W +: MSE_W];
  end

  assign hit = (mseHeld >= thrTable[scanIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mseHeld <= '0;
    else if (cmd.load) mseHeld <= mseIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualityIdx   <= '0;
      qualityValid <= 1'b0;
    end else if (cmd.zero) begin
      qualityIdx   <= '0;
      qualityValid <= 1'b1;
    end else if (cmd.finish) begin
      qualityIdx   <= scanIdx;
      qualityValid <= 1'b1;
    end else begin
      qualityValid <= 1'b0;
    end
  end

  // R1: the registered grade's threshold is met by the held reading
  p_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.finish |=> (mseHeld >= thrTable[qualityIdx]))
    else $error("grade threshold not met");

  // R1: the threshold one grade worse was not met (first match)
  p_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (qualityValid && qualityIdx != '0) |-> (mseHeld < thrTable[qualityIdx - 1'b1]))
    else $error("earlier threshold was met");

  // R5: link-down path reports grade 0 on the next cycle
  p_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.zero |=> (qualityValid && qualityIdx == '0))
    else $error("link-down grade not zero");

  // R6: valid is a single-cycle pulse
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    qualityValid |=> !qualityValid)
    else $error("valid held two cycles");

  // R7: the reading does not change while its result is reported
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    qualityValid |=> $stable(mseHeld))
    else $error("reading replaced during report");

endmodule

// File: rtl/sqi_quantizer.sv
module sqi_quantizer
  import sqi_pkg::*;
#(
  parameter int MSE_W    = 16,
  parameter int NUM_BINS = 8,
  parameter logic [NUM_BINS*MSE_W-1:0] THRESHOLDS = {
    16'h0000, 16'h015B, 16'h01B6, 16'h0227,
    16'h02B6, 16'h0369, 16'h044C, 16'h0569},
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [MSE_W-1:0] mseValue,
  input  logic             linkUp,
  output logic [IDX_W-1:0] qualityIdx,
  output logic             qualityValid,
  output logic [IDX_W-1:0] qualityMax
);

  sqiCmd_t          cmd;
  logic [IDX_W-1:0] scanIdx;
  logic             hit;

  assign qualityMax = IDX_W'(NUM_BINS - 1);

  sqi_ctrl #(.NUM_BINS(NUM_BINS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .linkUp     (linkUp),
    .hit        (hit),
    .cmd        (cmd),
    .scanIdx    (scanIdx)
  );

  sqi_datapath #(
    .MSE_W     (MSE_W),
    .NUM_BINS  (NUM_BINS),
    .THRESHOLDS(THRESHOLDS)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .scanIdx     (scanIdx),
    .mseIn       (mseValue),
    .hit         (hit),
    .qualityIdx  (qualityIdx),
    .qualityValid(qualityValid)
  );

endmodule

// File: tb/test_sqi_quantizer.sv
module test_sqi_quantizer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] mseValue = '0;
  logic        linkUp = 1'b0;
  logic [2:0]  qualityIdx;
  logic        qualityValid;
  logic [2:0]  qualityMax;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  logic [15:0] refThr [8] = '{16'h0569, 16'h044C, 16'h0369, 16'h02B6,
                              16'h0227, 16'h01B6, 16'h015B, 16'h0000};

  always #4 clk = ~clk;  // 125 MHz

  sqi_quantizer i_sqi_quantizer (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .mseValue(mseValue),
    .linkUp(linkUp), .qualityIdx(qualityIdx), .qualityValid(qualityValid),
    .qualityMax(qualityMax)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Applies one strobe and measures edges to the valid pulse and the grade.
  task automatic runSample(logic [15:0] mse, logic link, int expIdx, int expEdges, string req);
    int edges = 0;
    @(negedge clk);
    sampleValid = 1'b1; mseValue = mse; linkUp = link;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      sampleValid = 1'b0;
      if (qualityValid) break;
    end
    check(qualityValid == 1'b1, req, "valid seen", int'(qualityValid), 1);
    check(int'(qualityIdx) == expIdx, req, "grade", int'(qualityIdx), expIdx);
    check(edges == expEdges, "R4", "edges to valid", edges, expEdges);
    @(negedge clk);
    check(qualityValid == 1'b0, "R6", "valid pulse width", int'(qualityValid), 0);
  endtask

  task automatic testReset();
    check(qualityValid == 1'b0, "R9", "reset valid", int'(qualityValid), 0);
    check(qualityIdx == 3'd0, "R9", "reset grade", int'(qualityIdx), 0);
    check(qualityMax == 3'd7, "R8", "max grade", int'(qualityMax), 7);
  endtask

  task automatic testBoundaries();
    for (int k = 0; k < 8; k++) begin
      runSample(refThr[k], 1'b1, k, k + 2, "R10");
      if (k < 7) runSample(refThr[k] - 16'd1, 1'b1, k + 1, k + 3, "R10");
    end
  endtask

  task automatic testExtremes();
    runSample(16'hFFFF, 1'b1, 0, 2, "R2");
    runSample(16'h0800, 1'b1, 0, 2, "R2");
    runSample(16'h0000, 1'b1, 7, 9, "R3");
    runSample(16'h0100, 1'b1, 7, 9, "R3");
    runSample(16'h0300, 1'b1, 3, 5, "R1");
    runSample(16'h01C0, 1'b1, 5, 7, "R1");
    check(qualityMax == 3'd7, "R8", "max grade after scans", int'(qualityMax), 7);
  endtask

  task automatic testLinkDown();
    runSample(16'h0000, 1'b0, 0, 1, "R5");
    runSample(16'hFFFF, 1'b0, 0, 1, "R5");
    runSample(16'h0200, 1'b0, 0, 1, "R5");
  endtask

  // A strobe during a scan must not disturb it.
  task automatic testBusyScan();
    int pulses = 0;
    int lastIdx = -1;
    @(negedge clk);
    sampleValid = 1'b1; mseValue = 16'h0000; linkUp = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b1; mseValue = 16'hFFFF; linkUp = 1'b0;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0;
    if (qualityValid) begin pulses++; lastIdx = int'(qualityIdx); end
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (qualityValid) begin pulses++; lastIdx = int'(qualityIdx); end
    end
    check(pulses == 1, "R7", "results during scan", pulses, 1);
    check(lastIdx == 7, "R7", "grade from first strobe", lastIdx, 7);
  endtask

  // A strobe in the cycle of the valid pulse must be dropped.
  task automatic testBusyReport();
    int pulses = 0;
    @(negedge clk);
    sampleValid = 1'b1; mseValue = 16'hFFFF; linkUp = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(qualityValid == 1'b1, "R7", "first result", int'(qualityValid), 1);
    sampleValid = 1'b1; mseValue = 16'h0000;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (qualityValid) pulses++;
      @(posedge clk); @(negedge clk);
    end
    check(pulses == 0, "R7", "results from dropped strobe", pulses, 0);
    check(qualityIdx == 3'd0, "R7", "grade kept", int'(qualityIdx), 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBoundaries();
    testExtremes();
    testLinkDown();
    testBusyScan();
    testBusyReport();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule